// File: doc/BRIEF.md
# Linked-List Register Capture Engine

This block walks a compact transfer list held at the bottom of its own word-addressed SRAM. It then reads the words the list names over a read-only memory master port. Software loads the list through a host SRAM port, sets the configuration, raises the list-enable bit and writes the trigger register. The engine then decodes the list one word at a time. A word with its top bit set supplies a new base address. Any other nonzero word carries two relative offset/length pairs. A zero word ends the walk.

The engine works in one of two functions. In capture mode with the SRAM sink selected, every fetched word is appended to SRAM, starting at the index held in the RAM configuration register. In checksum mode the fetched words are folded into a CRC-32. The first walk after enable stores that result as the reference. Each later walk compares its result with the reference and flags a mismatch in the status register. A capture that would run past the last SRAM word stops the walk and raises an interrupt status bit.

Top module: `ll_capture_engine`

## Requirements
- R1: After reset the status register (0x24) reads 0x10 (bit 4 ready set, bit 0 mismatch clear), interrupt status (0x34) reads 0, `mem_req` is low and `irq` is low.
- R2: A list word with bit 31 set is a base word. Its bits 27:0, shifted left by 4, give the byte base address, and the running word offset restarts at zero.
- R3: Any other nonzero list word holds two pairs, bits 15:0 handled before bits 31:16. In each pair, bits 7:0 are added to the running word offset and bits 14:8 give a length N. The engine then fetches the N byte addresses base + 4 × (offset + i), for i = 0 to N−1, in that order.
- R4: A pair whose length field is zero is skipped and its offset increment is not applied, so the upper half 0x0001 of a single-pair link word fetches nothing.
- R5: A zero list word, or reaching the end of SRAM, ends the walk, and status bit 4 returns to 1.
- R6: In capture mode (config 0x1C bit 0 = 0) with the SRAM sink (bit 4 = 1), the k-th fetched word is written to SRAM index ramcfg + k, where ramcfg is register 0x18. Afterwards register 0x2C reads ramcfg + number of words written, and register 0x28 reads the byte address of the last fetch.
- R7: In capture mode with the trace sink (bit 4 = 0), the words are fetched but SRAM is left unchanged and register 0x2C stays at ramcfg.
- R8: In checksum mode (bit 0 = 1), a CRC-32 (polynomial 0x04C11DB7, initial value all ones, MSB first) is taken over the fetched words and SRAM is not written. The first walk after list-enable goes from 0 to 1 stores the reference. A later walk with a different result sets status bit 0, which stays set until list-enable is raised again.
- R9: Writing 1 to the trigger register 0x20 starts a walk only while list-enable (0x14 bit 0) is 1 and the engine is ready; otherwise the write is ignored.
- R10: A capture word that arrives with the write pointer at the SRAM depth is dropped. The walk then ends, interrupt status bit 0 is set, and `irq` equals interrupt enable (0x30 bit 0) AND interrupt status bit 0. Writing 0 to interrupt status bit 0 clears it.
- R11: Writing 0 to list-enable during a walk returns the engine to ready within two clock edges, and `mem_req` is then low.
- R12: `mem_req` stays high with a stable `mem_addr` until `mem_valid` is returned, and only one read is outstanding at a time.
- R13: Register 0x00 reads the version parameter and register 0x04 reads the SRAM depth in words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ram_wr_en | input | 1 | Host SRAM write strobe, accepted while ready |
| ram_addr | input | AW | Host SRAM word index |
| ram_wdata | input | 32 | Host SRAM write data |
| ram_rdata | output | 32 | Host SRAM read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_valid | input | 1 | Read data returned for the pending request |
| mem_rdata | input | 32 | Memory read data |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that the memory side returns `mem_valid` only for a request that is pending, one cycle after it is seen. They also assume that software changes the function, sink and RAM configuration only while the engine is ready, and the RTL ignores such writes while a walk runs. The bench memory model answers every request exactly one cycle late with data derived from the address. All configuration and list writes are made between walks. List-enable is cleared mid-walk only in the abort test.

// File: rtl/llc_pkg.sv
package llc_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_DECODE,
    WK_PAIR,
    WK_FETCH,
    WK_NEXT
  } walk_st_t;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

  localparam logic [7:0] RG_VERSION = 8'h00;
  localparam logic [7:0] RG_INFO    = 8'h04;
  localparam logic [7:0] RG_LISTEN  = 8'h14;
  localparam logic [7:0] RG_RAMCFG  = 8'h18;
  localparam logic [7:0] RG_CFG     = 8'h1C;
  localparam logic [7:0] RG_TRIG    = 8'h20;
  localparam logic [7:0] RG_STATUS  = 8'h24;
  localparam logic [7:0] RG_FADDR   = 8'h28;
  localparam logic [7:0] RG_SADDR   = 8'h2C;
  localparam logic [7:0] RG_INTEN   = 8'h30;
  localparam logic [7:0] RG_INTST   = 8'h34;
endpackage

// File: rtl/llc_ram.sv
module llc_ram #(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   host_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [31:0]   eng_wdata,
  input  logic [AW-1:0] eng_raddr,
  output logic [31:0]   eng_rdata
);
  logic [31:0] mem_q [WORDS];

  always_ff @(posedge clk) begin
    if (eng_we) begin
      mem_q[eng_waddr] <= eng_wdata;
    end else if (host_we) begin
      mem_q[host_addr] <= host_wdata;
    end
  end

  assign host_rdata = mem_q[host_addr];
  assign eng_rdata  = mem_q[eng_raddr];
endmodule

// File: rtl/llc_crc_step.sv
module llc_crc_step #(
  parameter logic [31:0] POLY = 32'h04C1_1DB7,
  parameter int          DW   = 32
) (
  input  logic [31:0]   crc_in,
  input  logic [DW-1:0] data,
  output logic [31:0]   crc_out
);
  logic [31:0] stage [DW+1];

  assign stage[0] = crc_in;
  for (genvar g = 0; g < DW; g++) begin : g_bit
    logic fb;
    assign fb = stage[g][31] ^ data[DW-1-g];
    assign stage[g+1] = {stage[g][30:0], 1'b0} ^ (fb ? POLY : 32'h0);
  end
  assign crc_out = stage[DW];
endmodule

// File: rtl/llc_walker.sv
module llc_walker
  import llc_pkg::*;
#(
  parameter int WORDS = 64,
  parameter int OFF_W = 16,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_l,
  input  logic          start,
  input  logic          abort,
  input  logic          func_crc,
  input  logic          sink_sram,
  input  logic [AW:0]   wr_base,
  output logic [AW-1:0] lst_addr,
  input  logic [31:0]   lst_word,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [31:0]   wr_data,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_valid,
  input  logic [31:0]   mem_rdata,
  output logic          busy,
  output logic [31:0]   fetch_addr,
  output logic [AW:0]   wr_ptr,
  output logic          crc_done,
  output logic [31:0]   crc_val,
  output logic          ovf
);
  localparam logic [AW:0] END_IX = (AW+1)'(WORDS);

  walk_st_t         st_q, st_d;
  logic [AW:0]      lptr_q, lptr_d;
  logic [27:0]      base_q, base_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             half_q, half_d;
  logic [6:0]       len_q, len_d;
  logic [6:0]       idx_q, idx_d;
  logic [AW:0]      wptr_q, wptr_d;
  logic [31:0]      crc_q, crc_d;
  logic [31:0]      faddr_q, faddr_d;
  logic [31:0]      crc_nx;
  logic [15:0]      pair;
  logic [31:0]      word_ix;
  logic             done;
  logic             unused_bits;

  assign unused_bits = ^{lst_word[30:28], pair[15]};

  llc_crc_step #(.POLY(CRC_POLY), .DW(32)) u_crc (
    .crc_in (crc_q),
    .data   (mem_rdata),
    .crc_out(crc_nx)
  );

  assign pair     = half_q ? lst_word[31:16] : lst_word[15:0];
  assign word_ix  = 32'(off_q) + 32'(idx_q);
  assign mem_addr = {base_q, 4'h0} + {word_ix[29:0], 2'b00};
  assign mem_req  = (st_q == WK_FETCH);
  assign lst_addr = lptr_q[AW-1:0];
  assign wr_addr  = wptr_q[AW-1:0];
  assign wr_data  = mem_rdata;

  always_comb begin
    st_d    = st_q;
    lptr_d  = lptr_q;
    base_d  = base_q;
    off_d   = off_q;
    half_d  = half_q;
    len_d   = len_q;
    idx_d   = idx_q;
    wptr_d  = wptr_q;
    crc_d   = crc_q;
    faddr_d = faddr_q;
    wr_en   = 1'b0;
    done    = 1'b0;
    ovf     = 1'b0;
    case (st_q)
      WK_IDLE: begin
        if (start) begin
          st_d   = WK_DECODE;
          lptr_d = '0;
          base_d = '0;
          off_d  = '0;
          half_d = 1'b0;
          wptr_d = wr_base;
          crc_d  = '1;
        end
      end
      WK_DECODE: begin
        if (lptr_q == END_IX || lst_word == 32'h0) begin
          st_d = WK_IDLE;
          done = 1'b1;
        end else if (lst_word[31]) begin
          base_d = lst_word[27:0];
          off_d  = '0;
          lptr_d = lptr_q + 1'b1;
        end else begin
          half_d = 1'b0;
          st_d   = WK_PAIR;
        end
      end
      WK_PAIR: begin
        if (pair[14:8] == 7'd0) begin
          st_d = WK_NEXT;
        end else begin
          off_d = off_q + OFF_W'(pair[7:0]);
          len_d = pair[14:8];
          idx_d = '0;
          st_d  = WK_FETCH;
        end
      end
      WK_FETCH: begin
        faddr_d = mem_addr;
        if (mem_valid) begin
          if (func_crc) begin
            crc_d = crc_nx;
          end else if (sink_sram) begin
            if (wptr_q >= END_IX) begin
              ovf  = 1'b1;
              st_d = WK_IDLE;
            end else begin
              wr_en  = 1'b1;
              wptr_d = wptr_q + 1'b1;
            end
          end
          if (st_d == WK_FETCH) begin
            if (idx_q == len_q - 7'd1) begin
              st_d = WK_NEXT;
            end else begin
              idx_d = idx_q + 7'd1;
            end
          end
        end
      end
      WK_NEXT: begin
        if (!half_q) begin
          half_d = 1'b1;
          st_d   = WK_PAIR;
        end else begin
          half_d = 1'b0;
          lptr_d = lptr_q + 1'b1;
          st_d   = WK_DECODE;
        end
      end
      default: st_d = WK_IDLE;
    endcase
    if (abort && st_q != WK_IDLE) begin
      st_d  = WK_IDLE;
      wr_en = 1'b0;
      done  = 1'b0;
      ovf   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      st_q    <= WK_IDLE;
      lptr_q  <= '0;
      base_q  <= '0;
      off_q   <= '0;
      half_q  <= 1'b0;
      len_q   <= '0;
      idx_q   <= '0;
      wptr_q  <= '0;
      crc_q   <= '1;
      faddr_q <= '0;
    end else begin
      st_q    <= st_d;
      lptr_q  <= lptr_d;
      base_q  <= base_d;
      off_q   <= off_d;
      half_q  <= half_d;
      len_q   <= len_d;
      idx_q   <= idx_d;
      wptr_q  <= wptr_d;
      crc_q   <= crc_d;
      faddr_q <= faddr_d;
    end
  end

  assign busy       = (st_q != WK_IDLE);
  assign fetch_addr = faddr_q;
  assign wr_ptr     = wptr_q;
  assign crc_done   = done && func_crc;
  assign crc_val    = crc_q;
endmodule

// File: rtl/ll_capture_engine.sv
module ll_capture_engine
  import llc_pkg::*;
#(
  parameter int          RAM_WORDS  = 64,
  parameter int          OFF_W      = 16,
  parameter logic [31:0] HW_VERSION = 32'h0001_0200,
  localparam int         AW         = $clog2(RAM_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [7:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          ram_wr_en,
  input  logic [AW-1:0] ram_addr,
  input  logic [31:0]   ram_wdata,
  output logic [31:0]   ram_rdata,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_valid,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  logic [1:0]    rst_sync;
  logic          rst_l;

  logic          list_en_q, list_en_d;
  logic [AW:0]   ram_cfg_q, ram_cfg_d;
  logic          func_q, func_d;
  logic          sink_q, sink_d;
  logic          int_en_q, int_en_d;
  logic          int_st_q, int_st_d;
  logic [31:0]   ref_q, ref_d;
  logic          ref_vld_q, ref_vld_d;
  logic          mism_q, mism_d;

  logic          busy, start, trig_wr, crc_done, ovf;
  logic [31:0]   crc_val, fetch_addr;
  logic [AW:0]   wr_ptr;
  logic          eng_we;
  logic [AW-1:0] eng_waddr, lst_addr;
  logic [31:0]   eng_wdata, lst_word;
  logic          unused_wd;

  assign unused_wd = ^reg_wdata[31:AW+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_l = rst_sync[1];

  assign trig_wr = reg_wr_en && (reg_addr == RG_TRIG) && reg_wdata[0];
  assign start   = trig_wr && list_en_q && !busy;

  llc_ram #(.WORDS(RAM_WORDS)) u_ram (
    .clk       (clk),
    .host_we   (ram_wr_en && !busy),
    .host_addr (ram_addr),
    .host_wdata(ram_wdata),
    .host_rdata(ram_rdata),
    .eng_we    (eng_we),
    .eng_waddr (eng_waddr),
    .eng_wdata (eng_wdata),
    .eng_raddr (lst_addr),
    .eng_rdata (lst_word)
  );

  llc_walker #(.WORDS(RAM_WORDS), .OFF_W(OFF_W)) u_walk (
    .clk       (clk),
    .rst_l     (rst_l),
    .start     (start),
    .abort     (!list_en_q),
    .func_crc  (func_q),
    .sink_sram (sink_q),
    .wr_base   (ram_cfg_q),
    .lst_addr  (lst_addr),
    .lst_word  (lst_word),
    .wr_en     (eng_we),
    .wr_addr   (eng_waddr),
    .wr_data   (eng_wdata),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .fetch_addr(fetch_addr),
    .wr_ptr    (wr_ptr),
    .crc_done  (crc_done),
    .crc_val   (crc_val),
    .ovf       (ovf)
  );

  always_comb begin
    list_en_d = list_en_q;
    ram_cfg_d = ram_cfg_q;
    func_d    = func_q;
    sink_d    = sink_q;
    int_en_d  = int_en_q;
    int_st_d  = int_st_q;
    ref_d     = ref_q;
    ref_vld_d = ref_vld_q;
    mism_d    = mism_q;
    if (reg_wr_en) begin
      case (reg_addr)
        RG_LISTEN: begin
          list_en_d = reg_wdata[0];
          if (reg_wdata[0] && !list_en_q) begin
            ref_vld_d = 1'b0;
            mism_d    = 1'b0;
          end
        end
        RG_RAMCFG: if (!busy) ram_cfg_d = reg_wdata[AW:0];
        RG_CFG: begin
          if (!busy) begin
            func_d = reg_wdata[0];
            sink_d = reg_wdata[4];
          end
        end
        RG_INTEN: int_en_d = reg_wdata[0];
        RG_INTST: int_st_d = int_st_q & reg_wdata[0];
        default: ;
      endcase
    end
    if (ovf) int_st_d = 1'b1;
    if (crc_done) begin
      if (!ref_vld_q) begin
        ref_d     = crc_val;
        ref_vld_d = 1'b1;
      end else if (crc_val != ref_q) begin
        mism_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      list_en_q <= 1'b0;
      ram_cfg_q <= '0;
      func_q    <= 1'b0;
      sink_q    <= 1'b1;
      int_en_q  <= 1'b0;
      int_st_q  <= 1'b0;
      ref_q     <= '0;
      ref_vld_q <= 1'b0;
      mism_q    <= 1'b0;
    end else begin
      list_en_q <= list_en_d;
      ram_cfg_q <= ram_cfg_d;
      func_q    <= func_d;
      sink_q    <= sink_d;
      int_en_q  <= int_en_d;
      int_st_q  <= int_st_d;
      ref_q     <= ref_d;
      ref_vld_q <= ref_vld_d;
      mism_q    <= mism_d;
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    case (reg_addr)
      RG_VERSION: reg_rdata = HW_VERSION;
      RG_INFO:    reg_rdata = 32'(RAM_WORDS);
      RG_LISTEN:  reg_rdata = {31'h0, list_en_q};
      RG_RAMCFG:  reg_rdata = 32'(ram_cfg_q);
      RG_CFG:     reg_rdata = {27'h0, sink_q, 3'h0, func_q};
      RG_STATUS:  reg_rdata = {27'h0, !busy, 3'h0, mism_q};
      RG_FADDR:   reg_rdata = fetch_addr;
      RG_SADDR:   reg_rdata = 32'(wr_ptr);
      RG_INTEN:   reg_rdata = {31'h0, int_en_q};
      RG_INTST:   reg_rdata = {31'h0, int_st_q};
      default:    reg_rdata = 32'h0;
    endcase
  end

  assign irq = int_en_q && int_st_q;
endmodule

// File: rtl/llc_checker.sv
module llc_checker #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_l,
  input logic          busy,
  input logic          list_en,
  input logic          trig_wr,
  input logic          mem_req,
  input logic          mem_valid,
  input logic [31:0]   mem_addr,
  input logic          eng_we,
  input logic [AW-1:0] eng_waddr,
  input logic [AW:0]   ram_cfg,
  input logic          int_st,
  input logic          mism
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_l)
    (mem_req && !mem_valid && list_en) |=> (mem_req && $stable(mem_addr)));

  assert_wr_window_R6: assert property (@(posedge clk) disable iff (!rst_l)
    eng_we |-> ({1'b0, eng_waddr} >= ram_cfg && mem_valid));

  assert_trig_ignored_R9: assert property (@(posedge clk) disable iff (!rst_l)
    (trig_wr && !list_en) |=> !busy);

  assert_ovf_ready_R10: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(int_st) |-> !busy);

  assert_mism_at_end_R8: assert property (@(posedge clk) disable iff (!rst_l)
    $rose(mism) |-> !busy);

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_l)
    (!list_en && busy) |=> !busy);
endmodule

bind ll_capture_engine llc_checker #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_l    (rst_l),
  .busy     (busy),
  .list_en  (list_en_q),
  .trig_wr  (trig_wr),
  .mem_req  (mem_req),
  .mem_valid(mem_valid),
  .mem_addr (mem_addr),
  .eng_we   (eng_we),
  .eng_waddr(eng_waddr),
  .ram_cfg  (ram_cfg_q),
  .int_st   (int_st_q),
  .mism     (mism_q)
);

// File: tb/tb_ll_capture_engine.sv
module tb_ll_capture_engine;
  localparam int CLK_NS = 10;
  localparam int WORDS  = 64;
  localparam int AW     = 6;
  localparam logic [7:0] A_VER = 8'h00, A_INFO = 8'h04, A_EN = 8'h14,
    A_RCFG = 8'h18, A_CFG = 8'h1C, A_TRIG = 8'h20, A_STAT = 8'h24,
    A_FADDR = 8'h28, A_SADDR = 8'h2C, A_IEN = 8'h30, A_IST = 8'h34;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [7:0]    reg_addr = 8'h0;
  logic [31:0]   reg_wdata = 32'h0;
  logic [31:0]   reg_rdata;
  logic          ram_wr_en = 1'b0;
  logic [AW-1:0] ram_addr = '0;
  logic [31:0]   ram_wdata = 32'h0;
  logic [31:0]   ram_rdata;
  logic          mem_req;
  logic [31:0]   mem_addr;
  logic          mem_valid;
  logic [31:0]   mem_rdata;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] salt = 32'h1234_5678;
  logic [31:0] seen[$];
  logic [31:0] exp_a[$];
  logic [31:0] img[WORDS];
  int n_img;
  bit pend;
  int pend_ix;
  logic [31:0] cur_base;
  int cur_off;

  always #(CLK_NS/2) clk = ~clk;

  ll_capture_engine #(.RAM_WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ram_wr_en(ram_wr_en),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ salt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid <= 1'b0;
      mem_rdata <= 32'h0;
    end else begin
      mem_valid <= mem_req && !mem_valid;
      mem_rdata <= mdata(mem_addr);
      if (mem_req && mem_valid) seen.push_back(mem_addr);
    end
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ram_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    ram_addr = AW'(a); ram_wdata = d; ram_wr_en = 1'b1;
    @(negedge clk);
    ram_wr_en = 1'b0;
  endtask

  task automatic ram_rd(input int a, output logic [31:0] d);
    ram_addr = AW'(a);
    #1;
    d = ram_rdata;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      reg_rd(A_STAT, s);
      if (s[4]) return;
    end
  endtask

  task automatic lb_reset();
    n_img = 0; pend = 0; cur_base = 0; cur_off = 0;
    exp_a.delete();
  endtask

  task automatic lb_flush();
    if (pend) img[pend_ix] = img[pend_ix] | 32'h0001_0000;
    pend = 0;
  endtask

  task automatic lb_base(input logic [27:0] f);
    lb_flush();
    img[n_img] = {4'h8, f};
    n_img++;
    cur_base = {f, 4'h0};
    cur_off = 0;
  endtask

  task automatic lb_pair(input int inc, input int len);
    logic [15:0] p;
    p = {1'b0, 7'(len), 8'(inc)};
    if (!pend) begin
      img[n_img] = {16'h0, p}; pend_ix = n_img; n_img++; pend = 1;
    end else begin
      img[pend_ix] = img[pend_ix] | {p, 16'h0}; pend = 0;
    end
    if (len != 0) begin
      cur_off += inc;
      for (int i = 0; i < len; i++) exp_a.push_back(cur_base + 32'(4 * (cur_off + i)));
    end
  endtask

  task automatic lb_end();
    lb_flush();
    img[n_img] = 32'h0;
    n_img++;
    for (int i = 0; i < n_img; i++) ram_wr(i, img[i]);
    reg_wr(A_RCFG, 32'(n_img));
  endtask

  task automatic walk();
    seen.delete();
    reg_wr(A_TRIG, 32'h1);
    wait_ready();
  endtask

  task automatic check_capture(input string tag);
    logic [31:0] d;
    chk({tag, " R3 fetch count"}, 32'(seen.size()), 32'(exp_a.size()));
    for (int k = 0; k < exp_a.size() && k < seen.size(); k++) begin
      chk({tag, " R3 R2 fetch address"}, seen[k], exp_a[k]);
      ram_rd(n_img + k, d);
      chk({tag, " R6 captured word"}, d, mdata(exp_a[k]));
    end
    reg_rd(A_SADDR, d);
    chk({tag, " R6 sram addr reg"}, d, 32'(n_img + exp_a.size()));
    if (exp_a.size() > 0) begin
      reg_rd(A_FADDR, d);
      chk({tag, " R6 fetch addr reg"}, d, exp_a[exp_a.size()-1]);
    end
    reg_rd(A_STAT, d);
    chk({tag, " R5 ready after end"}, d & 32'h10, 32'h10);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    reg_rd(A_STAT, d);  chk("R1 status after reset", d, 32'h10);
    reg_rd(A_IST, d);   chk("R1 int status after reset", d, 32'h0);
    chk("R1 mem_req after reset", {31'h0, mem_req}, 32'h0);
    chk("R1 irq after reset", {31'h0, irq}, 32'h0);
    reg_rd(A_VER, d);   chk("R13 version", d, 32'h0001_0200);
    reg_rd(A_INFO, d);  chk("R13 depth", d, 32'(WORDS));

    // R9: trigger ignored while list-enable is 0
    lb_reset(); lb_base(28'h40); lb_pair(0, 2); lb_end();
    reg_wr(A_CFG, 32'h10);
    seen.delete();
    reg_wr(A_TRIG, 32'h1);
    reg_rd(A_STAT, d);  chk("R9 still ready", d & 32'h10, 32'h10);
    repeat (6) @(negedge clk);
    chk("R9 no fetch", 32'(seen.size()), 32'h0);

    reg_wr(A_EN, 32'h1);

    // R4 skip of a zero-length pair, single-pair link words, two bases
    lb_reset();
    lb_base(28'h10); lb_pair(9, 0); lb_pair(2, 3); lb_pair(5, 1);
    lb_base(28'h20); lb_pair(0, 2); lb_end();
    walk();
    check_capture("R4 skip list");

    // R5: empty list
    lb_reset(); lb_end();
    walk();
    check_capture("R5 empty list");

    // R3 sweep of increments and lengths
    for (int inc = 0; inc < 4; inc++) begin
      for (int len = 1; len < 4; len++) begin
        lb_reset();
        lb_base(28'(32'h40 + inc)); lb_pair(inc, len); lb_pair(inc + 1, len);
        lb_pair(255, 1);
        lb_base(28'h800); lb_pair(1, len); lb_end();
        salt = salt + 32'h0101_0101;
        walk();
        check_capture("R3 sweep");
      end
    end

    // R7: trace sink leaves SRAM alone
    lb_reset(); lb_base(28'h55); lb_pair(1, 3); lb_end();
    ram_wr(n_img, 32'hCAFE_F00D);
    reg_wr(A_CFG, 32'h00);
    walk();
    chk("R7 fetch count", 32'(seen.size()), 32'd3);
    ram_rd(n_img, d);  chk("R7 sram untouched", d, 32'hCAFE_F00D);
    reg_rd(A_SADDR, d); chk("R7 sram addr reg", d, 32'(n_img));

    // R8: checksum reference and compare
    reg_wr(A_CFG, 32'h01);
    reg_wr(A_EN, 32'h0); reg_wr(A_EN, 32'h1);
    walk();
    reg_rd(A_STAT, d); chk("R8 first walk no mismatch", d, 32'h10);
    walk();
    reg_rd(A_STAT, d); chk("R8 same data no mismatch", d, 32'h10);
    salt = salt ^ 32'h0000_0100;
    walk();
    reg_rd(A_STAT, d); chk("R8 changed data mismatch", d, 32'h11);
    walk();
    reg_rd(A_STAT, d); chk("R8 mismatch sticky", d, 32'h11);
    ram_rd(n_img, d);  chk("R8 sram untouched", d, 32'hCAFE_F00D);
    reg_wr(A_EN, 32'h0); reg_wr(A_EN, 32'h1);
    reg_rd(A_STAT, d); chk("R8 re-enable clears", d, 32'h10);
    walk();
    reg_rd(A_STAT, d); chk("R8 new reference", d, 32'h10);

    // R11: abort a long capture walk
    reg_wr(A_CFG, 32'h10);
    lb_reset(); lb_base(28'h300); lb_pair(0, 127); lb_end();
    seen.delete();
    reg_wr(A_TRIG, 32'h1);
    repeat (20) @(negedge clk);
    reg_rd(A_STAT, d); chk("R11 busy before abort", d & 32'h10, 32'h0);
    reg_wr(A_EN, 32'h0);
    @(negedge clk);
    reg_rd(A_STAT, d); chk("R11 ready after abort", d & 32'h10, 32'h10);
    chk("R11 no request", {31'h0, mem_req}, 32'h0);

    // R10: overflow of the capture area
    reg_wr(A_EN, 32'h1);
    reg_wr(A_IEN, 32'h1);
    walk();
    reg_rd(A_IST, d);   chk("R10 int status set", d, 32'h1);
    chk("R10 irq", {31'h0, irq}, 32'h1);
    reg_rd(A_SADDR, d); chk("R10 pointer at depth", d, 32'(WORDS));
    reg_rd(A_STAT, d);  chk("R10 ready", d & 32'h10, 32'h10);
    chk("R10 fetches until overflow", 32'(seen.size()), 32'(WORDS - n_img + 1));
    ram_rd(WORDS - 1, d);
    chk("R10 last word", d, mdata(exp_a[WORDS - 1 - n_img]));
    reg_wr(A_IST, 32'h0);
    reg_rd(A_IST, d);   chk("R10 int status cleared", d, 32'h0);
    chk("R10 irq cleared", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule